// File: doc/BRIEF.md
# DRAM Parallel Test-Mode Logic

This block models the mode and data logic of a four-bit-wide dynamic memory that supports a compressed parallel test. It runs on a system clock and samples the active-low row strobe, column strobe, write strobe and output enable on each rising edge. It also samples a shared 10-bit address and a 4-bit data input. Strobe edges are found by comparing each sample with the one before it. The storage array is cut down to a parameterised number of rows and columns so that it fits in simulation.

A refresh cycle is recognised when the column strobe is already low at the edge where the row strobe is first seen low. The write strobe sampled at that edge decides the mode. A low write strobe switches the block into test mode, and a high one switches it back to normal mode. A row-only cycle, in which the column strobe never falls while the row strobe is low, also leaves test mode.

In test mode, each data pin stands for two cells whose column addresses differ only in one selected column bit. A write loads the pin level into both cells. A read returns a per-pin agreement flag instead of stored data. In normal mode, that column bit selects one of the two cells in the usual way.

Top module: `dram_test_logic`

## Requirements
- R1: In normal mode, a column-strobe fall with the write strobe low and the row open stores `dqIn` in one cell. The row is the low ROW_W address bits sampled when the row strobe fell. The column is the low COL_W address bits sampled when the column strobe fell.
- R2: In normal mode, a column-strobe fall with the write strobe high loads the addressed cell into `dqOut`. The PAIR_BIT column bit selects between the two cells of a pair. The output data changes only on such a read.
- R3: A refresh cycle is one where the column strobe is low at the sample where the row strobe is first seen low. This includes both strobes falling between the same two edges. With the write strobe low, the block enters test mode. With the write strobe high, it leaves test mode. A refresh cycle writes no cell and changes no stored data.
- R4: A row-only cycle leaves test mode. In such a cycle the row strobe falls with the column strobe high, then rises with no column-strobe fall in between.
- R5: A test-mode write stores each pin of `dqIn` into both cells of its pair. The pair is the addressed column with PAIR_BIT forced to 0 and to 1.
- R6: On a test-mode read, `dqOut` bit i is 1 when the two cells of the pair agree on bit i and 0 when they differ. The PAIR_BIT address bit has no effect on the result.
- R7: `dqEn` is high only while a read access is active and both the column strobe and the output enable are low. It rises in the cycle after the clock edge that samples the column-strobe fall of a read. It drops as soon as the column strobe or the output enable goes high. It stays low for the whole of a write access.
- R8: Reset clears test mode and drives `dqEn` low. Stored cells keep their contents through reset.
- R9: Normal read and write cycles do not change the mode. Test mode persists until a valid exit cycle.
- R10: While the row strobe stays low, each further column-strobe fall performs a new access in the same row. The column for each access comes from the address sampled at that fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| wN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | 10 | Multiplexed row and column address |
| dqIn | input | 4 | Write data from the pins |
| dqOut | output | 4 | Read data or per-pin agreement flags |
| dqEn | output | 1 | Output-drive enable; low means high impedance |

## Verification
Two functions can fall into the same sample: a row-strobe fall and a column-strobe fall. The block has to decide whether that sample is a mode-changing refresh or the start of an access. The bench provokes this by dropping both strobes between two clock edges, with the write strobe low and a conflicting word on `dqIn`. It judges the result in two steps. A following read must return agreement flags, which shows that test mode was entered. After a later exit, a normal read of the cell that the falling address pointed at must still return its old word, which shows that nothing was written.

// File: rtl/dram_tm_pkg.sv
package dram_tm_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  // Access strobes passed from the sequencer to the cell array
  typedef struct packed {
    logic wrEn;      // store pin data this cycle
    logic rdLoad;    // capture read result this cycle
    logic pairMode;  // pin maps onto a cell pair
  } arrayCmd_t;
endpackage

// File: rtl/dram_tm_ctrl.sv
module dram_tm_ctrl
  import dram_tm_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int ROW_W  = 3,
  parameter int COL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              wN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  output arrayCmd_t         cmd,
  output logic [ROW_W-1:0]  rowSel,
  output logic [COL_W-1:0]  colSel,
  output logic              dqEn
);
  timeunit 1ns;
  timeprecision 100ps;

  logic rasQ, casQ;
  logic rowOpen, casUsed, testMode, readActive;
  logic [ROW_W-1:0] rowQ;

  logic rasFall, rasRise, casFall, accessGo;

  assign rasFall  = rasQ & ~rasN;
  assign rasRise  = ~rasQ & rasN;
  assign casFall  = casQ & ~casN;
  assign accessGo = casFall & rowOpen & ~rasN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasQ       <= 1'b1;
      casQ       <= 1'b1;
      rowOpen    <= 1'b0;
      casUsed    <= 1'b0;
      testMode   <= 1'b0;
      readActive <= 1'b0;
      rowQ       <= '0;
    end else begin
      rasQ <= rasN;
      casQ <= casN;
      if (rasFall) begin
        casUsed <= 1'b0;
        if (!casN) begin
          // refresh cycle: write strobe level picks the mode
          testMode <= ~wN;
          rowOpen  <= 1'b0;
        end else begin
          rowOpen <= 1'b1;
          rowQ    <= addr[ROW_W-1:0];
        end
      end else if (rasRise) begin
        if (rowOpen && !casUsed) testMode <= 1'b0;
        rowOpen <= 1'b0;
      end else if (casFall && rowOpen) begin
        casUsed <= 1'b1;
      end
      if (casN) readActive <= 1'b0;
      else if (accessGo) readActive <= wN;
    end
  end

  assign cmd.wrEn     = accessGo & ~wN;
  assign cmd.rdLoad   = accessGo & wN;
  assign cmd.pairMode = testMode;
  assign rowSel       = rowQ;
  assign colSel       = addr[COL_W-1:0];
  assign dqEn         = readActive & ~casN & ~oeN;

  // R3
  entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rasQ && !rasN && !casN && !wN) |=> testMode);

  // R4
  ras_only_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rasQ && rasN && rowOpen && !casUsed) |=> !testMode);

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rasN == rasQ) |=> $stable(testMode));

  // R7
  cas_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    casN |=> !readActive);

  // R7
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrEn |=> !dqEn);
endmodule

// File: rtl/dram_tm_array.sv
module dram_tm_array
  import dram_tm_pkg::*;
#(
  parameter int ROW_W    = 3,
  parameter int COL_W    = 4,
  parameter int DQ_W     = 4,
  parameter int PAIR_BIT = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  arrayCmd_t        cmd,
  input  logic [ROW_W-1:0] rowSel,
  input  logic [COL_W-1:0] colSel,
  input  logic [DQ_W-1:0]  dqIn,
  output logic [DQ_W-1:0]  dqOut
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [COL_W-1:0] PAIR_MASK = COL_W'(1) << PAIR_BIT;

  logic [DQ_W-1:0] cells [DEPTH];
  logic [IDX_W-1:0] idxN, idxLo, idxHi;
  logic [DQ_W-1:0] agree, readWord;

  assign idxN  = {rowSel, colSel};
  assign idxLo = {rowSel, colSel & ~PAIR_MASK};
  assign idxHi = {rowSel, colSel | PAIR_MASK};

  // per-pin pair comparison
  for (genvar i = 0; i < DQ_W; i++) begin : g_cmp
    assign agree[i] = ~(cells[idxLo][i] ^ cells[idxHi][i]);
  end

  assign readWord = cmd.pairMode ? agree : cells[idxN];

  always_ff @(posedge clk) begin
    if (cmd.wrEn) begin
      if (cmd.pairMode) begin
        cells[idxLo] <= dqIn;
        cells[idxHi] <= dqIn;
      end else begin
        cells[idxN] <= dqIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dqOut <= '0;
    else if (cmd.rdLoad) dqOut <= readWord;
  end

  // R5
  pair_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrEn && cmd.pairMode) |=> (cells[$past(idxLo)] == cells[$past(idxHi)]));

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.rdLoad |=> $stable(dqOut));
endmodule

// File: rtl/dram_test_logic.sv
module dram_test_logic
  import dram_tm_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int ROW_W    = 3,
  parameter int COL_W    = 4,
  parameter int DQ_W     = 4,
  parameter int PAIR_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              wN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dqIn,
  output logic [DQ_W-1:0]   dqOut,
  output logic              dqEn
);
  timeunit 1ns;
  timeprecision 100ps;

  arrayCmd_t        cmd;
  logic [ROW_W-1:0] rowSel;
  logic [COL_W-1:0] colSel;

  dram_tm_ctrl #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .wN(wN), .oeN(oeN),
    .addr(addr), .cmd(cmd), .rowSel(rowSel), .colSel(colSel), .dqEn(dqEn)
  );

  dram_tm_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .PAIR_BIT(PAIR_BIT)) u_array (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rowSel(rowSel), .colSel(colSel),
    .dqIn(dqIn), .dqOut(dqOut)
  );

  // R8
  reset_quiet_chk: assert property (@(posedge clk) !rstN |-> !dqEn);
endmodule

// File: tb/sim_dram_test_logic.sv
module sim_dram_test_logic;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int ROWS = 8;
  localparam int COLS = 16;

  logic clk = 0, rstN = 0, rasN = 1, casN = 1, wN = 1, oeN = 1;
  logic [9:0] addr = '0;
  logic [3:0] dqIn = '0;
  logic [3:0] dqOut;
  logic dqEn;
  int checks = 0, errors = 0;
  logic [3:0] rd;
  logic en;

  dram_test_logic u0 (.clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .wN(wN),
    .oeN(oeN), .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqEn(dqEn));

  always #2.5 clk = ~clk;

  task automatic tick; @(posedge clk); #1; endtask

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pat(int r, int c);
    return 4'(r * 7 + c * 3 + 5);
  endfunction

  function automatic logic [3:0] cmpOf(int r, int c);
    return ~(pat(r, c & ~1) ^ pat(r, c | 1));
  endfunction

  task automatic wrCycle(int r, int c, logic [3:0] d);
    addr = 10'(r); rasN = 0; tick;
    addr = 10'(c); wN = 0; dqIn = d; casN = 0; tick;
    casN = 1; wN = 1; rasN = 1; tick;
  endtask

  task automatic rdCycle(int r, int c, output logic [3:0] d, output logic e);
    addr = 10'(r); rasN = 0; tick;
    addr = 10'(c); wN = 1; oeN = 0; casN = 0; tick;
    d = dqOut; e = dqEn;
    casN = 1; oeN = 1; rasN = 1; tick;
  endtask

  task automatic cbr(logic w);
    casN = 0; tick;
    wN = w; rasN = 0; tick;
    rasN = 1; casN = 1; wN = 1; tick;
  endtask

  task automatic rasOnly(int r);
    addr = 10'(r); rasN = 0; tick;
    rasN = 1; tick;
  endtask

  initial begin
    #750000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick; tick;
    check("R8 reset dqEn", {3'b0, dqEn}, 4'h0);
    rstN = 1; tick;

    // R1 R2: normal sweep
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) wrCycle(r, c, pat(r, c));
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        rdCycle(r, c, rd, en);
        check("R1 R2 normal read", rd, pat(r, c));
        if (r == 0 && c == 0) check("R7 read enable", {3'b0, en}, 4'h1);
      end

    // R3 entry, R6 compare, R9 persistence across many reads
    cbr(1'b0);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        rdCycle(r, c, rd, en);
        check("R6 R9 test read", rd, cmpOf(r, c));
      end

    // R5 pair write in test mode
    wrCycle(2, 5, 4'hA);
    rdCycle(2, 4, rd, en);
    check("R5 test pair agree", rd, 4'hF);
    cbr(1'b1);
    rdCycle(2, 4, rd, en);
    check("R5 low cell", rd, 4'hA);
    rdCycle(2, 5, rd, en);
    check("R5 high cell", rd, 4'hA);
    rdCycle(3, 3, rd, en);
    check("R3 data kept over refresh", rd, pat(3, 3));

    // R4 row-only exit
    cbr(1'b0);
    rdCycle(1, 0, rd, en);
    check("R4 in test", rd, cmpOf(1, 0));
    rasOnly(3);
    rdCycle(1, 0, rd, en);
    check("R4 after exit", rd, pat(1, 0));

    // R3 simultaneous strobe fall counts as refresh, no write
    addr = 10'd0; dqIn = ~pat(0, 0); wN = 0; rasN = 0; casN = 0; tick;
    rasN = 1; casN = 1; wN = 1; tick;
    rdCycle(0, 0, rd, en);
    check("R3 joint fall enters", rd, cmpOf(0, 0));
    cbr(1'b1);
    rdCycle(0, 0, rd, en);
    check("R3 joint fall no write", rd, pat(0, 0));

    // R7 output enable behaviour
    addr = 10'd4; rasN = 0; tick;
    addr = 10'd7; wN = 1; casN = 0; tick;
    check("R7 oe high", {3'b0, dqEn}, 4'h0);
    oeN = 0; #0.5;
    check("R7 oe low", {3'b0, dqEn}, 4'h1);
    check("R7 data", dqOut, pat(4, 7));
    oeN = 1; #0.5;
    check("R7 oe raised", {3'b0, dqEn}, 4'h0);
    oeN = 0; #0.5;
    check("R7 oe relowered", {3'b0, dqEn}, 4'h1);
    casN = 1; #0.5;
    check("R7 cas raised", {3'b0, dqEn}, 4'h0);
    tick; oeN = 1; rasN = 1; tick;
    addr = 10'd4; rasN = 0; oeN = 0; tick;
    addr = 10'd7; wN = 0; dqIn = pat(4, 7); casN = 0; tick;
    check("R7 write quiet", {3'b0, dqEn}, 4'h0);
    tick;
    check("R7 write quiet later", {3'b0, dqEn}, 4'h0);
    casN = 1; wN = 1; oeN = 1; rasN = 1; tick;

    // R10 page-mode writes within one row
    addr = 10'd6; rasN = 0; tick;
    addr = 10'd2; wN = 0; dqIn = 4'h3; casN = 0; tick;
    casN = 1; tick;
    addr = 10'd9; dqIn = 4'hC; casN = 0; tick;
    casN = 1; wN = 1; rasN = 1; tick;
    rdCycle(6, 2, rd, en);
    check("R10 page first", rd, 4'h3);
    rdCycle(6, 9, rd, en);
    check("R10 page second", rd, 4'hC);

    // R8 reset leaves test mode, keeps cells
    cbr(1'b0);
    rstN = 0; tick; tick;
    check("R8 dqEn in reset", {3'b0, dqEn}, 4'h0);
    rstN = 1; tick;
    rdCycle(6, 2, rd, en);
    check("R8 normal after reset", rd, 4'h3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule